// File: doc/BRIEF.md
# Flash Program Command and Status Register Block

This block is the register front end of a flash controller as the host sees it. It sits on a simple synchronous register bus. Through it the host writes a program command, waits for the routine to complete, reads the interrupt and status words, and clears the interrupt. The array access itself is not modelled. A fixed-latency timer stands in for the internal program routine. The outcome of each routine comes from two inputs: one says the target block is locked, and the other forces a program failure.

Once a routine has started, the block refuses every command except a reset. A reset stops the routine at once. If a routine was running when the reset arrived, the block raises a sticky corruption flag. An optional auto-clear mode drops the interrupt bits each time a new program command is accepted, so the host does not have to clear them by hand.

Top module: `flash_cmd_regs`

## Requirements
- R1: Writing 0x0080 or 0x001A to address 0xF220 while idle starts a routine. `busy` rises at the clock edge that samples the write and then stays high for exactly LATENCY cycles.
- R2: While `busy` is high, any write to 0xF220 other than RESET_CMD is ignored. This includes another program code. Neither the command read-back nor the completion time changes.
- R3: Writing RESET_CMD to 0xF220 clears `busy` and the status error and lock bits on the next edge. It sets no interrupt bit.
- R4: A RESET_CMD write accepted while `busy` is high sets `corrupt`. `corrupt` stays set until the next program command is accepted. A reset written while idle leaves `corrupt` low.
- R5: When a routine completes, bit 15 (overall) and bit 6 (write done) of the interrupt word at 0xF241 are set.
- R6: Writing 0x0000 to 0xF241 clears both interrupt bits. Writing any other value there changes nothing.
- R7: The status word at 0xF240 has three live bits: bit 15 shows `busy`, bit 14 reports lock, and bit 10 reports error. The lock and error bits are cleared when a program is accepted. At completion they are set from `lock_in` and `err_inject`, which are sampled when the command is accepted. A locked block also sets the error bit. All other bits read zero.
- R8: A read returns its data on `rdata` one cycle after the request. Address 0xF220 returns the last accepted command code. Every address other than 0xF220, 0xF240 and 0xF241 returns zero.
- R9: When `auto_int_clr` is high, accepting a program command clears both interrupt bits. When it is low, the interrupt bits are left as they were.
- R10: While idle, a write to 0xF220 of a value that is neither a program code nor RESET_CMD is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel | input | 1 | Bus access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after a read request |
| lock_in | input | 1 | Target block is locked (sampled at command acceptance) |
| err_inject | input | 1 | Force a program error (sampled at command acceptance) |
| auto_int_clr | input | 1 | Clear interrupt bits when a program command is accepted |
| busy | output | 1 | Internal program routine running |
| corrupt | output | 1 | A reset interrupted a running program |

## Verification
The bench builds the block with LATENCY = 6 and RESET_CMD = 0x00F0. A latency of six cycles leaves room to issue commands, reads and resets part-way through a routine, while keeping each routine short enough that many random lock, error and auto-clear combinations fit in a single run. The reset code is distinct from both program codes, so the bench can hit an abort in the middle of a routine, a reset while idle, and a rejected foreign code as separate cases.

// File: rtl/flash_regs_pkg.sv
package flash_regs_pkg;
  localparam int REG_W = 16;

  localparam logic [REG_W-1:0] ADDR_CMD  = 16'hF220;
  localparam logic [REG_W-1:0] ADDR_STAT = 16'hF240;
  localparam logic [REG_W-1:0] ADDR_INT  = 16'hF241;

  localparam logic [REG_W-1:0] CODE_PROG_A = 16'h0080;
  localparam logic [REG_W-1:0] CODE_PROG_B = 16'h001A;

  localparam int INT_ALL_BIT = 15;
  localparam int INT_WR_BIT  = 6;
  localparam int ST_BUSY_BIT = 15;
  localparam int ST_LOCK_BIT = 14;
  localparam int ST_ERR_BIT  = 10;

  typedef struct packed {
    logic start;      // program command accepted
    logic abort;      // reset command seen
    logic int_clear;  // zero written to interrupt word
  } cmd_evt_t;
endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_regs_pkg::*;
#(
  parameter logic [REG_W-1:0] RESET_CMD = 16'h00F0
) (
  input  logic             wr_en,
  input  logic [REG_W-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  input  logic             busy,
  output cmd_evt_t         evt
);
  logic cmd_hit;
  logic prog_code;

  always_comb begin
    cmd_hit       = wr_en && (addr == ADDR_CMD);
    prog_code     = (wdata == CODE_PROG_A) || (wdata == CODE_PROG_B);
    evt.start     = cmd_hit && prog_code && !busy;
    evt.abort     = cmd_hit && (wdata == RESET_CMD);
    evt.int_clear = wr_en && (addr == ADDR_INT) && (wdata == '0);
  end
endmodule

// File: rtl/flash_prog_timer.sv
module flash_prog_timer #(
  parameter int LATENCY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick_en;

  always_comb begin
    busy_d  = busy_q;
    cnt_d   = cnt_q;
    tick_en = abort || start || busy_q;
    if (abort) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (tick_en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0) && !abort;
endmodule

// File: rtl/flash_status_regs.sv
module flash_status_regs
  import flash_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_evt_t         evt,
  input  logic             done,
  input  logic             busy,
  input  logic             lock_in,
  input  logic             err_inject,
  input  logic             auto_int_clr,
  input  logic [REG_W-1:0] wdata,
  output logic             int_all,
  output logic             int_wr,
  output logic             st_err,
  output logic             st_lock,
  output logic             corrupt,
  output logic [REG_W-1:0] last_cmd
);
  logic             int_q, int_d;
  logic             err_q, err_d, lock_q, lock_d;
  logic             cap_lock_q, cap_err_q;
  logic             corrupt_q, corrupt_d;
  logic [REG_W-1:0] cmd_q;
  logic             cmd_en;

  always_comb begin
    int_d = int_q;
    if (done)                           int_d = 1'b1;
    else if (evt.int_clear)             int_d = 1'b0;
    else if (evt.start && auto_int_clr) int_d = 1'b0;

    err_d  = err_q;
    lock_d = lock_q;
    if (evt.abort || evt.start) begin
      err_d  = 1'b0;
      lock_d = 1'b0;
    end else if (done) begin
      err_d  = cap_lock_q || cap_err_q;
      lock_d = cap_lock_q;
    end

    corrupt_d = corrupt_q;
    if (evt.abort && busy) corrupt_d = 1'b1;
    else if (evt.start)    corrupt_d = 1'b0;

    cmd_en = evt.start || evt.abort;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q     <= 1'b0;
      err_q     <= 1'b0;
      lock_q    <= 1'b0;
      corrupt_q <= 1'b0;
    end else begin
      int_q     <= int_d;
      err_q     <= err_d;
      lock_q    <= lock_d;
      corrupt_q <= corrupt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_lock_q <= 1'b0;
      cap_err_q  <= 1'b0;
    end else if (evt.start) begin
      cap_lock_q <= lock_in;
      cap_err_q  <= err_inject;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= wdata;
  end

  assign int_all  = int_q;
  assign int_wr   = int_q;
  assign st_err   = err_q;
  assign st_lock  = lock_q;
  assign corrupt  = corrupt_q;
  assign last_cmd = cmd_q;
endmodule

// File: rtl/flash_cmd_regs.sv
module flash_cmd_regs
  import flash_regs_pkg::*;
#(
  parameter int               LATENCY   = 8,
  parameter logic [REG_W-1:0] RESET_CMD = 16'h00F0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             we,
  input  logic [REG_W-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             lock_in,
  input  logic             err_inject,
  input  logic             auto_int_clr,
  output logic             busy,
  output logic             corrupt
);
  logic             rst_sync_n;
  logic             wr_en, rd_en;
  cmd_evt_t         evt;
  logic             done;
  logic             int_all, int_wr, st_err, st_lock;
  logic [REG_W-1:0] last_cmd;
  logic [REG_W-1:0] rd_mux;
  logic [REG_W-1:0] rdata_q;

  assign wr_en = sel && we;
  assign rd_en = sel && !we;

  flash_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  flash_cmd_decode #(.RESET_CMD(RESET_CMD)) u_dec (
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .busy  (busy),
    .evt   (evt)
  );

  flash_prog_timer #(.LATENCY(LATENCY)) u_tmr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (evt.start),
    .abort (evt.abort),
    .busy  (busy),
    .done  (done)
  );

  flash_status_regs u_st (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .evt          (evt),
    .done         (done),
    .busy         (busy),
    .lock_in      (lock_in),
    .err_inject   (err_inject),
    .auto_int_clr (auto_int_clr),
    .wdata        (wdata),
    .int_all      (int_all),
    .int_wr       (int_wr),
    .st_err       (st_err),
    .st_lock      (st_lock),
    .corrupt      (corrupt),
    .last_cmd     (last_cmd)
  );

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      ADDR_CMD: rd_mux = last_cmd;
      ADDR_STAT: begin
        rd_mux[ST_BUSY_BIT] = busy;
        rd_mux[ST_LOCK_BIT] = st_lock;
        rd_mux[ST_ERR_BIT]  = st_err;
      end
      ADDR_INT: begin
        rd_mux[INT_ALL_BIT] = int_all;
        rd_mux[INT_WR_BIT]  = int_wr;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else if (rd_en)  rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/flash_cmd_regs_chk.sv
module flash_cmd_regs_chk
  import flash_regs_pkg::*;
#(
  parameter int               LATENCY   = 8,
  parameter logic [REG_W-1:0] RESET_CMD = 16'h00F0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             we,
  input logic [REG_W-1:0] addr,
  input logic [REG_W-1:0] wdata,
  input logic             busy,
  input logic             corrupt,
  input logic             int_all,
  input logic             int_wr,
  input logic             st_err,
  input logic             st_lock
);
  logic        cmd_wr, rst_wr, prog_wr;
  logic [31:0] run_len;

  assign cmd_wr  = sel && we && (addr == ADDR_CMD);
  assign rst_wr  = cmd_wr && (wdata == RESET_CMD);
  assign prog_wr = cmd_wr && ((wdata == CODE_PROG_A) || (wdata == CODE_PROG_B));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= '0;
  end

  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_wr && !busy) |=> busy);

  assert_busy_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < LATENCY));

  assert_reset_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> (!busy && !st_err && !st_lock));

  assert_corrupt_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_wr && busy) |=> corrupt);

  assert_done_int_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(rst_wr)) |-> (int_all && int_wr));

  assert_lock_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_lock |-> st_err);
endmodule

bind flash_cmd_regs flash_cmd_regs_chk #(.LATENCY(LATENCY), .RESET_CMD(RESET_CMD)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .sel     (sel),
  .we      (we),
  .addr    (addr),
  .wdata   (wdata),
  .busy    (busy),
  .corrupt (corrupt),
  .int_all (int_all),
  .int_wr  (int_wr),
  .st_err  (st_err),
  .st_lock (st_lock)
);

// File: tb/flash_cmd_regs_test.sv
module flash_cmd_regs_test;
  localparam int          LAT  = 6;
  localparam logic [15:0] RCMD = 16'h00F0;
  localparam logic [15:0] A_CMD = 16'hF220, A_ST = 16'hF240, A_INT = 16'hF241;

  logic        clk, rst_n, sel, we, lock_in, err_inject, auto_int_clr;
  logic [15:0] addr, wdata, rdata;
  logic        busy, corrupt;
  int          checks, errors;

  flash_cmd_regs #(.LATENCY(LAT), .RESET_CMD(RCMD)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lock_in(lock_in), .err_inject(err_inject),
    .auto_int_clr(auto_int_clr), .busy(busy), .corrupt(corrupt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] exp_stat(bit b, bit lk, bit er);
    logic [15:0] r;
    r = '0;
    r[15] = b;
    r[14] = lk;
    r[10] = lk | er;
    return r;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [15:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(logic [15:0] a, output logic [15:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    d = rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    int n;
    checks = 0; errors = 0;
    sel = 0; we = 0; addr = 0; wdata = 0;
    lock_in = 0; err_inject = 0; auto_int_clr = 0;
    rst_n = 0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // reset state (R7, R8)
    check("R1 busy after reset", {15'd0, busy}, 16'd0);
    check("R4 corrupt after reset", {15'd0, corrupt}, 16'd0);
    bus_read(A_ST, rd);  check("R7 status reset", rd, 16'h0000);
    bus_read(A_INT, rd); check("R5 int reset", rd, 16'h0000);
    bus_read(A_CMD, rd); check("R8 cmd reset", rd, 16'h0000);

    // R10 foreign code while idle
    bus_write(A_CMD, 16'h0055);
    check("R10 no start", {15'd0, busy}, 16'd0);
    bus_read(A_CMD, rd); check("R10 cmd readback", rd, 16'h0000);

    // R1 length, R5, R7 clean outcome
    bus_write(A_CMD, 16'h0080);
    wait_idle(n);
    check("R1 busy length", 16'(n), 16'(LAT));
    bus_read(A_INT, rd); check("R5 int set", rd, 16'h8040);
    bus_read(A_ST, rd);  check("R7 clean status", rd, exp_stat(0, 0, 0));

    // R6 nonzero write ignored, zero clears
    bus_write(A_INT, 16'h8040);
    bus_read(A_INT, rd); check("R6 nonzero ignored", rd, 16'h8040);
    bus_write(A_INT, 16'h0000);
    bus_read(A_INT, rd); check("R6 zero clears", rd, 16'h0000);

    // R2 second program while busy ignored
    lock_in = 1;
    bus_write(A_CMD, 16'h001A);
    lock_in = 0;
    bus_write(A_CMD, 16'h0080);
    bus_read(A_CMD, rd); check("R2 cmd unchanged", rd, 16'h001A);
    bus_read(A_ST, rd);  check("R7 status busy", rd, exp_stat(1, 0, 0));
    wait_idle(n);
    check("R2 completion time", 16'(n + 3), 16'(LAT));
    bus_read(A_ST, rd);  check("R7 lock outcome", rd, exp_stat(0, 1, 1));

    // R3 reset while idle: no corrupt, status cleared, no int
    bus_write(A_INT, 16'h0000);
    bus_write(A_CMD, RCMD);
    check("R4 idle reset no corrupt", {15'd0, corrupt}, 16'd0);
    bus_read(A_ST, rd);  check("R3 status cleared", rd, 16'h0000);
    bus_read(A_INT, rd); check("R3 no int", rd, 16'h0000);
    bus_read(A_CMD, rd); check("R8 cmd reset code", rd, RCMD);

    // R3/R4 reset during a routine
    err_inject = 1;
    bus_write(A_CMD, 16'h0080);
    err_inject = 0;
    bus_write(A_CMD, RCMD);
    check("R3 busy cleared", {15'd0, busy}, 16'd0);
    check("R4 corrupt set", {15'd0, corrupt}, 16'd1);
    repeat (LAT + 2) @(negedge clk);
    bus_read(A_INT, rd); check("R3 abort no int", rd, 16'h0000);
    bus_read(A_ST, rd);  check("R3 abort status", rd, 16'h0000);
    bus_write(A_CMD, 16'h001A);
    check("R4 corrupt cleared", {15'd0, corrupt}, 16'd0);
    wait_idle(n);

    // R8 unmapped
    bus_read(16'hF221, rd); check("R8 unmapped F221", rd, 16'h0000);
    bus_read(16'h1234, rd); check("R8 unmapped 1234", rd, 16'h0000);

    // R9 auto clear vs manual
    bus_read(A_INT, rd); check("R5 int before auto", rd, 16'h8040);
    auto_int_clr = 0;
    bus_write(A_CMD, 16'h0080);
    bus_read(A_INT, rd); check("R9 manual keeps int", rd, 16'h8040);
    wait_idle(n);
    auto_int_clr = 1;
    bus_write(A_CMD, 16'h0080);
    auto_int_clr = 0;
    bus_read(A_INT, rd); check("R9 auto clears int", rd, 16'h0000);
    wait_idle(n);

    // random mix of outcomes
    for (int i = 0; i < 40; i++) begin
      bit lk, er, au, code;
      logic [15:0] junk;
      lk = 1'($urandom); er = 1'($urandom); au = 1'($urandom); code = 1'($urandom);
      junk = 16'($urandom) | 16'h0001;
      lock_in = lk; err_inject = er; auto_int_clr = au;
      bus_write(A_CMD, code ? 16'h001A : 16'h0080);
      lock_in = ~lk; err_inject = ~er; auto_int_clr = 0;
      bus_read(A_INT, rd);
      check("R9 random int during busy", rd, au ? 16'h0000 : 16'h8040);
      wait_idle(n);
      check("R1 random length", 16'(n + 1), 16'(LAT));
      bus_read(A_ST, rd);  check("R7 random status", rd, exp_stat(0, lk, er));
      bus_write(A_INT, junk);
      bus_read(A_INT, rd); check("R6 random junk write", rd, 16'h8040);
    end

    finish_run();
  end
endmodule